// File: doc/BRIEF.md
# Status Register Write Protection Unit

This block keeps the two block-protect bits and the write-enable latch for a serial memory. It also answers one question in every cycle: may the byte at the presented address be written now? The serial command engine in front of it decodes the opcodes. It passes single-cycle strobes for enable, disable, status write (with the received data byte) and the end of a memory write frame. It also presents the current byte address.

The block returns two things. The first is the status byte for read-back, laid out with its fixed constant bits. The second is a combinational write-allow bit. The memory write path gates each byte with that bit.

The block-protect field stands for retained storage. It is loaded with a preset value at reset. A status write changes it only while the write-enable latch is set. Every completed status write or memory write frame drops the latch, so each protected change needs a fresh enable command.

Top module: `wp_status_unit`

## Requirements
- R1: Status byte bits 7, 5, 4 and 0 always read 0, and bit 6 always reads 1.
- R2: Status bit 3 is block-protect bit 1, bit 2 is block-protect bit 0, and bit 1 is the write-enable latch.
- R3: An enable strobe alone sets the latch in the cycle after the strobe.
- R4: A disable strobe clears the latch in the next cycle.
- R5: Bit 1 of the status write data never sets the latch, and a status write always leaves the latch cleared.
- R6: A status write with the latch set loads the protect field from data bits 3:2 and ignores data bits 7:4 and 1:0.
- R7: A status write with the latch clear leaves the protect field unchanged.
- R8: An end-of-write strobe clears the latch in the next cycle.
- R9: Synchronous active-low reset clears the latch and loads the protect field with the preset `BP_INIT` (default 00). With the default preset the status byte reads 0x40.
- R10: The protect codes map as follows. Code 00 protects nothing. Code 01 protects addresses whose top two bits are 11. Code 10 protects addresses whose top bit is 1. Code 11 protects every address.
- R11: write_allow is 1 only when the latch is set and the address lies outside the protected range.
- R12: When an enable strobe arrives in the same cycle as a disable, status write or end-of-write strobe, the latch ends cleared. A status write in that cycle is judged on the latch value from before the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wren | input | 1 | Enable-latch command strobe |
| cmd_wrdi | input | 1 | Disable-latch command strobe |
| cmd_wrsr | input | 1 | Status write strobe |
| wrsr_data | input | 8 | Data byte carried by the status write |
| write_done | input | 1 | End of a memory write frame |
| wr_addr | input | ADDR_W (15) | Byte address under test |
| status_byte | output | 8 | Formatted status register |
| write_allow | output | 1 | The addressed byte may be written |

## Verification
The latch can be driven by two functions in the same cycle. The enable command may coincide with a disable, with a status write, or with the end of a write frame. A status write can also arrive in the cycle that the enable is still being taken. The bench provokes each of these overlaps by pulsing the strobes together. A behavioural model is built around the rule that clearing wins, and that status writes see the latch value from before the cycle. The bench compares the status byte and write_allow with this model on every clock, and adds named checks at the protect-range edges.

// File: rtl/wp_pkg.sv
// Package: shared types and constants for the write protection unit.
// Assumes an 8-bit status byte with a two-bit protect code at bits 3:2.
package wp_pkg;
    typedef enum logic [1:0] {
        PROT_NONE    = 2'b00,
        PROT_QUARTER = 2'b01,
        PROT_HALF    = 2'b10,
        PROT_ALL     = 2'b11
    } prot_code_t;

    localparam int STAT_BP_HI = 3;
    localparam int STAT_BP_LO = 2;
endpackage

// File: rtl/wp_enable_latch.sv
// Module: write-enable latch. Set by the enable command. Cleared by disable,
// by any status write and by the end of a write frame. Clearing wins.
// Assumes strobes are single-cycle pulses from the command decoder.
module wp_enable_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_dis_i,
    input  logic clr_wrsr_i,
    input  logic clr_done_i,
    output logic wel_o
);
    logic clr_any;

    // Collect every clearing cause.
    always_comb clr_any = clr_dis_i | clr_wrsr_i | clr_done_i;

    // Latch update with clear priority over set.
    always_ff @(posedge clk) begin
        if (!rst_n)       wel_o <= 1'b0;
        else if (clr_any) wel_o <= 1'b0;
        else if (set_i)   wel_o <= 1'b1;
    end

    a_r3_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
        set_i && !clr_dis_i && !clr_wrsr_i && !clr_done_i |=> wel_o);
    a_r4_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_dis_i |=> !wel_o);
    a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_done_i |=> !wel_o);
    a_r12_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i && clr_wrsr_i |=> !wel_o);
endmodule

// File: rtl/wp_bp_store.sv
// Module: protect-code store modelling retained bits. Loads a preset at reset
// and takes a new code only on a status write while the latch is set.
module wp_bp_store
    import wp_pkg::*;
#(
    parameter logic [1:0] BP_INIT = 2'b00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wrsr_i,
    input  logic       wel_i,
    input  logic [1:0] code_i,
    output prot_code_t code_o
);
    // Guarded load of the protect code.
    always_ff @(posedge clk) begin
        if (!rst_n)              code_o <= prot_code_t'(BP_INIT);
        else if (wrsr_i && wel_i) code_o <= prot_code_t'(code_i);
    end

    a_r7_locked_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        wrsr_i && !wel_i |=> $stable(code_o));
    a_r6_load_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        wrsr_i && wel_i |=> code_o == $past(code_i));
endmodule

// File: rtl/wp_range_check.sv
// Module: decides whether an address falls in the protected region, using
// only the top address bits. Assumes ADDR_W >= 2.
module wp_range_check
    import wp_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  prot_code_t        code_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              prot_o
);
    localparam int TOP = ADDR_W - 1;
    localparam int NXT = ADDR_W - 2;

    // Region decode per protect code.
    always_comb begin
        unique case (code_i)
            PROT_NONE:    prot_o = 1'b0;
            PROT_QUARTER: prot_o = addr_i[TOP] & addr_i[NXT];
            PROT_HALF:    prot_o = addr_i[TOP];
            default:      prot_o = 1'b1;
        endcase
    end

    always_comb begin
        a_r10_top_protected: assert (!(code_i == PROT_HALF && addr_i[TOP]) || prot_o);
        a_r10_none_free: assert (code_i != PROT_NONE || !prot_o);
    end
endmodule

// File: rtl/wp_status_unit.sv
// Module: top of the write protection unit. Holds the latch and protect
// code, formats the status byte and qualifies each write address.
// Assumes the command decoder supplies single-cycle, already-decoded strobes.
module wp_status_unit
    import wp_pkg::*;
#(
    parameter int         ADDR_W  = 15,
    parameter logic [1:0] BP_INIT = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic [7:0]        wrsr_data,
    input  logic              write_done,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        status_byte,
    output logic              write_allow
);
    logic       wel;
    prot_code_t code;
    logic       prot;
    logic       unused_wrsr_bits;

    // Data bits outside the protect field are deliberately ignored.
    always_comb unused_wrsr_bits = ^{wrsr_data[7:4], wrsr_data[1:0]};

    wp_enable_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (cmd_wren),
        .clr_dis_i  (cmd_wrdi),
        .clr_wrsr_i (cmd_wrsr),
        .clr_done_i (write_done),
        .wel_o      (wel)
    );

    wp_bp_store #(.BP_INIT(BP_INIT)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrsr_i (cmd_wrsr),
        .wel_i  (wel),
        .code_i (wrsr_data[STAT_BP_HI:STAT_BP_LO]),
        .code_o (code)
    );

    wp_range_check #(.ADDR_W(ADDR_W)) u_range (
        .code_i (code),
        .addr_i (wr_addr),
        .prot_o (prot)
    );

    // Status byte layout with constant bits around the live fields.
    always_comb status_byte = {1'b0, 1'b1, 2'b00, code, wel, 1'b0};

    // Final write qualification.
    always_comb write_allow = wel & ~prot;

    a_r11_no_write_without_latch: assert property (@(posedge clk) disable iff (!rst_n)
        !wel |-> !write_allow);
    a_r10_all_protected: assert property (@(posedge clk) disable iff (!rst_n)
        code == PROT_ALL |-> !write_allow);
    a_r5_data_bit_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wrsr && wrsr_data[1] |=> !status_byte[1]);
endmodule

// File: tb/wp_status_unit_bench.sv
module wp_status_unit_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wren = 0, wrdi = 0, wrsr = 0, done = 0;
    logic [7:0] wdata = 0;
    logic [14:0] addr = 0;
    logic [7:0] status;
    logic allow;
    int errors = 0, checks = 0;
    int m_wel = 0, m_bp = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    wp_status_unit u_wp_status_unit (
        .clk(clk), .rst_n(rst_n), .cmd_wren(wren), .cmd_wrdi(wrdi),
        .cmd_wrsr(wrsr), .wrsr_data(wdata), .write_done(done),
        .wr_addr(addr), .status_byte(status), .write_allow(allow));

    function automatic int exp_allow(int a);
        int prot;
        if (m_bp == 3) prot = 1;
        else if (m_bp == 2) prot = (a >= 16384);
        else if (m_bp == 1) prot = (a >= 24576);
        else prot = 0;
        return (m_wel == 1 && prot == 0) ? 1 : 0;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model updated on each clock.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_wel <= 0; m_bp <= 0;
        end else begin
            if (wrsr && m_wel == 1) m_bp <= wdata[3:2];
            if (wrdi || wrsr || done) m_wel <= 0;
            else if (wren) m_wel <= 1;
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) if (rst_n && !finished) begin
        int exp_st;
        exp_st = 8'h40 | (m_bp << 2) | (m_wel << 1);
        check((status & 8'hF1) == 8'h40, "R1", status & 8'hF1, 8'h40);
        check(status[3:2] == m_bp[1:0], "R6", status[3:2], m_bp);
        check(status[1] == m_wel[0], "R3", status[1], m_wel);
        check(int'(allow) == exp_allow(int'(addr)), "R11", allow, exp_allow(int'(addr)));
        if (status != exp_st[7:0]) check(0, "R2", status, exp_st);
    end

    task automatic pulse(input bit e, input bit d, input bit s, input logic [7:0] v, input bit f);
        @(posedge clk); #1;
        wren = e; wrdi = d; wrsr = s; wdata = v; done = f;
        @(posedge clk); #1;
        wren = 0; wrdi = 0; wrsr = 0; done = 0; wdata = 8'h00;
        #1;
    endtask

    task automatic probe(input int a, input bit exp, input string tag);
        addr = a[14:0]; #1;
        check(allow == exp, tag, allow, exp);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1; #1;
        check(status == 8'h40, "R9", status, 8'h40);
        probe(0, 0, "R11"); probe(16'h7FFF, 0, "R11");
        pulse(1, 0, 0, 0, 0);
        check(status == 8'h42, "R3", status, 8'h42);
        probe(16'h7FFF, 1, "R10");
        pulse(0, 1, 0, 0, 0);
        check(status == 8'h40, "R4", status, 8'h40);
        pulse(0, 0, 1, 8'h8C, 0);
        check(status == 8'h40, "R7", status, 8'h40);
        pulse(1, 0, 0, 0, 0);
        pulse(0, 0, 1, 8'hFF, 0);
        check(status == 8'h4C, "R6", status, 8'h4C);
        check(status[1] == 0, "R5", status[1], 0);
        pulse(1, 0, 0, 0, 0);
        probe(0, 0, "R10");
        pulse(0, 0, 1, 8'h04, 0);
        check(status == 8'h44, "R6", status, 8'h44);
        pulse(1, 0, 0, 0, 0);
        probe(16'h5FFF, 1, "R10"); probe(16'h6000, 0, "R10");
        pulse(0, 0, 1, 8'h08, 0);
        pulse(1, 0, 0, 0, 0);
        probe(16'h3FFF, 1, "R10"); probe(16'h4000, 0, "R10");
        pulse(0, 0, 0, 0, 1);
        check(status == 8'h48, "R8", status, 8'h48);
        pulse(1, 1, 0, 0, 0);
        check(status[1] == 0, "R12", status[1], 0);
        pulse(1, 0, 0, 0, 1);
        check(status[1] == 0, "R12", status[1], 0);
        pulse(1, 0, 1, 8'h00, 0);
        check(status == 8'h48, "R12", status, 8'h48);
        pulse(1, 0, 0, 0, 0);
        pulse(1, 0, 1, 8'h0C, 0);
        check(status == 8'h4C, "R12", status, 8'h4C);
        pulse(1, 0, 0, 0, 0);
        @(posedge clk); #1 rst_n = 0;
        @(posedge clk); #1 rst_n = 1; #1;
        check(status == 8'h40, "R9", status, 8'h40);
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule